// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus placed in front of a small byte-wide memory of 256 words. It watches the clock and data lines and finds start and stop conditions. After each start it takes in the first byte as a device select. That byte carries a fixed four-bit device type, three bits that must match three strap pins on the block, and a read/write flag. When the select matches, the slave pulls the data line low to acknowledge it. A write then takes a word address byte and one data byte, and the slave acknowledges each of them.

The data byte is not stored when it arrives. It is committed only when the master ends the transfer with a stop. That stop starts an internal write cycle whose length is a parameter counted in system clocks. While the cycle runs, a busy output is high and the slave is deaf to the bus: it does not acknowledge even its own select byte.

A read returns the single byte at the word address that was last received, sent most significant bit first. The outputs are a pull-low enable for the open-drain data line and the busy flag.

Top module: `twi_mem_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Both are judged on synchronised copies of the lines.
- R2: The select byte is taken in most significant bit first. It matches when bits 7..4 equal binary 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 is the read/write flag: 1 means read, 0 means write.
- R3: On a match, sda_drive_low_o is high through the ninth clock pulse. On a mismatch the line stays released for the rest of the transfer, up to the next start.
- R4: After a write select, the slave acknowledges the word address byte and then the data byte. It does not acknowledge any further byte in the same transfer.
- R5: A stop that follows a fully received data byte stores that byte at the word address and raises busy_o.
- R6: busy_o stays high for exactly WRITE_CYCLES clocks.
- R7: While busy_o is high, the slave never drives the data line and acknowledges no byte, including a matching select.
- R8: A stop that arrives before all eight data bits have been received discards the write: busy_o stays low and the memory word keeps its old value.
- R9: A start seen in the middle of a byte returns the receiver to the select phase. A complete transfer that follows is handled normally.
- R10: After a read select, the slave sends eight bits of the byte at the last received word address, most significant bit first, each bit held for a whole clock pulse. It then releases the line.
- R11: Right after reset, busy_o is low and sda_drive_low_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_i | input | 3 | Device select strap pins |
| sda_drive_low_o | output | 1 | High to pull the data line low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Random select bytes, with the type nibble and the strap field both varied, separate acknowledged matches from rejected mismatches. This also shows whether each field is compared on its own. Random address and data pairs are written and then read back through a bench model of the array, which exposes wrong bit order, a wrong store location or a lost commit. Directed transfers cut short by an early stop or by a start in mid-byte show whether partial data is thrown away. A select sent during the write cycle, together with a count of the busy cycles, shows the deaf period and its length.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_HOLD
  } slv_state_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } slv_phase_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_pipe;
  logic [CHAIN-1:0] sda_pipe;

  generate
    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_pipe[CHAIN-2];
  assign scl_old = scl_pipe[CHAIN-1];
  assign sda_now = sda_pipe[CHAIN-2];
  assign sda_old = sda_pipe[CHAIN-1];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
  assign sda_bit   = sda_now;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic [2:0]        strap,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              drive_low,
  output logic              commit,
  output logic [ADDR_W-1:0] word_ptr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  slv_state_t        state_q, state_d;
  slv_phase_t        phase_q, phase_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] txsh_q, txsh_d;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              dok_q, dok_d;
  logic              commit_q, commit_d;
  logic              sel_match;

  assign sel_match = (shreg_q[BYTE_W-1 -: 4] == DEV_TYPE) &&
                     (shreg_q[3:1] == strap);

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bcnt_d   = bcnt_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    rw_d     = rw_q;
    ptr_d    = ptr_q;
    data_d   = data_q;
    dok_d    = dok_q;
    commit_d = 1'b0;
    if (busy) begin
      state_d = ST_IDLE;
      phase_d = PH_DEV;
      dok_d   = 1'b0;
    end else if (start_det) begin
      state_d = ST_RX;
      phase_d = PH_DEV;
      bcnt_d  = '0;
      dok_d   = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      commit_d = dok_q;
      dok_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[BYTE_W-2:0], sda_bit};
            bcnt_d  = bcnt_q + 1'b1;
          end else if (scl_fall && bcnt_q == CNT_W'(BYTE_W)) begin
            unique case (phase_q)
              PH_DEV: begin
                if (sel_match) begin
                  state_d = ST_ACK;
                  rw_d    = shreg_q[0];
                end else begin
                  state_d = ST_HOLD;
                end
              end
              PH_WORD: begin
                ptr_d   = shreg_q[ADDR_W-1:0];
                state_d = ST_ACK;
              end
              default: begin
                data_d  = shreg_q;
                dok_d   = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt_d = '0;
            unique case (phase_q)
              PH_DEV: begin
                if (rw_q) begin
                  state_d = ST_TX;
                  txsh_d  = rd_data;
                end else begin
                  state_d = ST_RX;
                  phase_d = PH_WORD;
                end
              end
              PH_WORD: begin
                state_d = ST_RX;
                phase_d = PH_DATA;
              end
              default: state_d = ST_HOLD;
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            txsh_d = {txsh_q[BYTE_W-2:0], 1'b1};
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q == CNT_W'(BYTE_W - 1)) state_d = ST_TXACK;
          end
        end
        ST_TXACK: begin
          if (scl_fall) state_d = ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_DEV;
      bcnt_q   <= '0;
      shreg_q  <= '0;
      txsh_q   <= '1;
      rw_q     <= 1'b0;
      ptr_q    <= '0;
      data_q   <= '0;
      dok_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bcnt_q   <= bcnt_d;
      shreg_q  <= shreg_d;
      txsh_q   <= txsh_d;
      rw_q     <= rw_d;
      ptr_q    <= ptr_d;
      data_q   <= data_d;
      dok_q    <= dok_d;
      commit_q <= commit_d;
    end
  end

  assign drive_low = (state_q == ST_ACK) ||
                     ((state_q == ST_TX) && !txsh_q[BYTE_W-1]);
  assign commit    = commit_q;
  assign word_ptr  = ptr_q;
  assign wr_data   = data_q;
endmodule

// File: rtl/twi_mem_core.sv
module twi_mem_core
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              busy_q, busy_d;
  logic              wr_en;

  assign wr_en = commit && !busy_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];

  always_comb begin
    tmr_d  = tmr_q;
    busy_d = busy_q;
    if (wr_en) begin
      busy_d = 1'b1;
      tmr_d  = TW'(WRITE_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) busy_d = 1'b0;
      else             tmr_d  = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_drive_low_o,
  output logic       busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic commit, drive_low;
  logic [ADDR_W-1:0] word_ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit)
  );

  twi_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_bit   (sda_bit),
    .strap     (strap_i),
    .busy      (busy_o),
    .rd_data   (rd_data),
    .drive_low (drive_low),
    .commit    (commit),
    .word_ptr  (word_ptr),
    .wr_data   (wr_data)
  );

  twi_mem_core #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_core (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .commit  (commit),
    .addr    (word_ptr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .busy    (busy_o)
  );

  assign sda_drive_low_o = drive_low;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic sda_drive_low_o,
  input logic stop_det,
  input logic commit
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  AST_DEAF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_drive_low_o); // R7

  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !commit); // R7

  AST_COMMIT_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_det)); // R5

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit)); // R5

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == WRITE_CYCLES); // R6
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .sda_drive_low_o (sda_drive_low_o),
  .stop_det        (stop_det),
  .commit          (commit)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int  WC   = 600;
  localparam time Q    = 40ns;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic drv, busy;
  logic sda_line;
  int   checks = 0;
  int   fails = 0;
  int   busy_run = 0;
  int   last_run = 0;
  logic busy_prev = 1'b0;
  logic [7:0] model [256];

  always #4ns clk = ~clk;
  assign sda_line = sda_m & ~drv;

  twi_mem_slave #(.WRITE_CYCLES(WC)) i_twi_mem_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .strap_i         (STRAP),
    .sda_drive_low_o (drv),
    .busy_o          (busy)
  );

  always @(negedge clk) begin
    if (busy) busy_run <= busy_run + 1;
    else begin
      if (busy_prev) last_run <= busy_run;
      busy_run <= 0;
    end
    busy_prev <= busy;
  end

  function automatic bit exp_ack(input logic [7:0] sel);
    return (sel[7:4] == 4'b1010) && (sel[3:1] == STRAP);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bit(input logic b, output logic seen);
    sda_m = b; #Q; scl_m = 1'b1; #Q; seen = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    logic s;
    for (int i = 7; i > 7 - n; i--) send_bit(v[i], s);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    send_bit(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, s);
      v[i] = s;
    end
    send_bit(1'b1, s);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    #1ns;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output bit ok);
    bit k1, k2, k3;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, k1);
    send_byte(a, k2);
    send_byte(d, k3);
    bus_stop();
    ok = k1 && k2 && k3;
    model[a] = d;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v, output bit ok);
    bit k1, k2, k3;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, k1);
    send_byte(a, k2);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, k3);
    read_byte(v);
    bus_stop();
    ok = k1 && k2 && k3;
  endtask

  initial begin
    bit ok, k;
    logic [7:0] v;
    #33ns rst_n = 1'b1;
    #80ns;
    // R11 reset state
    check(busy == 1'b0, "R11 busy", busy, 0);
    check(drv == 1'b0, "R11 drive", drv, 0);

    // R1 R2 R3 R4 directed write
    do_write(8'h3C, 8'h5A, ok);
    check(ok, "R1 R2 R3 R4 write acks", ok, 1);
    #80ns;
    check(busy == 1'b1, "R5 busy after stop", busy, 1);
    // R7 own select ignored during write cycle
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, k);
    check(!k, "R7 ack while busy", k, 0);
    check(busy == 1'b1, "R7 still busy", busy, 1);
    bus_stop();
    wait_idle();
    #80ns;
    check(last_run == WC, "R6 busy length", last_run, WC);
    do_read(8'h3C, v, ok);
    check(ok && v == 8'h5A, "R10 read back", v, 8'h5A);

    // R4 extra byte after data not acknowledged
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, k);
    send_byte(8'h21, k);
    send_byte(8'h77, k);
    check(k, "R4 data ack", k, 1);
    send_byte(8'h99, k);
    check(!k, "R4 extra byte", k, 0);
    bus_stop();
    model[8'h21] = 8'h77;
    wait_idle();

    // R2 R3 strap mismatch, rest of transfer released
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, k);
    check(!k, "R2 strap mismatch", k, 0);
    send_byte(8'h10, k);
    check(!k, "R3 released after mismatch", k, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, k);
    check(!k, "R2 type mismatch", k, 0);
    bus_stop();

    // R8 stop inside data byte
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, k);
    send_byte(8'h3C, k);
    send_bits(4, 8'hF0);
    bus_stop();
    #200ns;
    check(busy == 1'b0, "R8 no write cycle", busy, 0);
    do_read(8'h3C, v, ok);
    check(v == 8'h5A, "R8 old value kept", v, 8'h5A);

    // R9 start in mid byte
    bus_start();
    send_bits(5, 8'hA5);
    do_write(8'h10, 8'hC3, ok);
    check(ok, "R9 acks after restart", ok, 1);
    wait_idle();
    do_read(8'h10, v, ok);
    check(v == 8'hC3, "R9 read after restart", v, 8'hC3);

    // R2 random select bytes, write flag kept clear
    for (int i = 0; i < 16; i++) begin
      logic [7:0] sel;
      sel = 8'($urandom) & 8'hFE;
      if (i % 3 == 0) sel = {4'b1010, 3'($urandom), 1'b0};
      bus_start();
      send_byte(sel, k);
      bus_stop();
      check(k == exp_ack(sel), "R2 random select", k, exp_ack(sel));
    end

    // R5 R10 random write then read back
    for (int i = 0; i < 18; i++) begin
      logic [7:0] a, d;
      a = 8'($urandom);
      d = 8'($urandom);
      do_write(a, d, ok);
      check(ok, "R5 random write acks", ok, 1);
      wait_idle();
      do_read(a, v, ok);
      check(ok && v == model[a], "R10 random read", v, model[a]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    #1ms;
    checks++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule